// File: doc/BRIEF.md
# Burst Data Timing Stage for a Synchronous DRAM

This block sits between the command decoder and the memory array of a synchronous DRAM. It times the data bus for burst transfers. A read start from the decoder opens a burst. In every beat of that burst the array supplies one word. The block holds each word back by a programmable column latency of two or three cycles, then drives it onto the bus together with an output enable. A write start opens a burst in which each bus word goes to the array in the same cycle, with a write strobe.

The byte mask pin acts differently in the two directions. During a write beat it blocks the current word at once. During a read it turns the output off two cycles after the mask is seen. Burst length comes from a small code: fixed lengths 1, 2, 4 and 8, or an open page burst. A single-write option shortens write bursts to one beat and leaves reads alone. A precharge ends the running burst. A new read or write replaces it. Array addressing and storage belong to other blocks.

Top module: `dq_burst_timer`

## Requirements
- R1: A read start in cycle n issues beat 0 in cycle n, with `arr_rdata` sampled in that cycle. Beat k is issued in cycle n+k. The word of each beat appears on `dq_out`, with `dq_oe` high, exactly L cycles after its issue cycle. L is 2 when `lat_sel`=0 and 3 when `lat_sel`=1.
- R2: `blen` is sampled at the start of a burst. Codes 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 beats. Code 3'b111 gives an open page burst. Codes 3'b100 to 3'b110 give 1 beat. Beats fall in consecutive cycles starting with the start cycle, and `arr_re` marks each read beat.
- R3: An open page burst issues a beat in every cycle with no limit of its own, until a stop or a new start ends it.
- R4: `arr_wbeat` marks each write beat, masked or not. In a write beat, `arr_we` equals the inverse of `dqm` in that same cycle. `arr_wdata` equals `dq_in` in a write beat and is zero in every other cycle.
- R5: `dqm` high in cycle n forces `dq_oe` low in cycle n+2 at either latency. It does not delay or drop the words of later cycles.
- R6: `cmd_stop` high in cycle n with no start in that cycle means no beat in cycle n and no beat after it from that burst. Read words issued before cycle n still reach the bus at their due cycles.
- R7: With `single_wr` high at a write start, the write burst is exactly one beat. Read bursts still follow `blen`.
- R8: A start during a running burst ends that burst and begins the new one in the same cycle. When several commands share one cycle, read wins over write and write wins over stop.
- R9: `dq_oe` is low in every cycle that has no read word due. `dq_out` is zero whenever `dq_oe` is low.
- R10: A write start in cycle n removes every read word still pending. `dq_oe` stays low from cycle n+1 until a later read brings new data due.
- R11: Reset is synchronous and active high. It leaves no burst running, no read word pending and no mask history, so after reset `dq_oe`, `arr_re`, `arr_wbeat` and `arr_we` stay low until a start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rd | input | 1 | Read start from the command decoder |
| cmd_wr | input | 1 | Write start from the command decoder |
| cmd_stop | input | 1 | Precharge of the bank, ends the burst |
| lat_sel | input | 1 | Column latency: 0 gives 2 cycles, 1 gives 3 cycles |
| blen | input | 3 | Burst length code |
| single_wr | input | 1 | Limit write bursts to one beat |
| dqm | input | 1 | Mask pin: write block now, read disable two cycles later |
| arr_rdata | input | DATA_W | Array word for the read beat of this cycle |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Bus output enable |
| arr_re | output | 1 | Read beat issued this cycle |
| arr_wbeat | output | 1 | Write beat this cycle |
| arr_we | output | 1 | Write strobe to the array, mask applied |
| arr_wdata | output | DATA_W | Write data to the array |

## Verification
The bench builds the block with a 16-bit data path and the default latencies of 2 and 3 cycles. That data width lets random words tell apart each read beat on `dq_out`. Both latencies are run, so the fixed two-cycle mask lag falls on a different beat offset in each setting. The open page code is part of the random mix, so bursts longer than eight beats meet mid-burst stops, restarts and flushes caused by writes.

// File: rtl/dqbt_pkg.sv
package dqbt_pkg;

    // Beat kind issued by the burst sequencer in a cycle
    typedef enum logic [1:0] {
        BEAT_NONE = 2'd0,
        BEAT_RD   = 2'd1,
        BEAT_WR   = 2'd2
    } beat_e;

    // Burst length codes
    localparam logic [2:0] LEN_CODE_1    = 3'b000;
    localparam logic [2:0] LEN_CODE_2    = 3'b001;
    localparam logic [2:0] LEN_CODE_4    = 3'b010;
    localparam logic [2:0] LEN_CODE_8    = 3'b011;
    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

    // Longest fixed burst and the counter width it needs
    localparam int FIX_MAX_BEATS = 8;
    localparam int LEFT_W        = $clog2(FIX_MAX_BEATS);

    // Cycles between the mask pin and the read output it disables
    localparam int MASK_LAG = 2;

    typedef struct packed {
        logic              act;   // more beats to issue
        logic              wr;    // burst direction
        logic              page;  // open page burst
        logic [LEFT_W-1:0] left;  // beats still to issue
    } burst_st_t;

    // Index of the last beat for a fixed-length code (reserved codes -> 1 beat)
    function automatic logic [LEFT_W-1:0] last_beat_idx(input logic [2:0] code);
        logic [LEFT_W-1:0] r;
        unique case (code)
            LEN_CODE_2: r = LEFT_W'(1);
            LEN_CODE_4: r = LEFT_W'(3);
            LEN_CODE_8: r = LEFT_W'(FIX_MAX_BEATS - 1);
            default:    r = '0;
        endcase
        return r;
    endfunction

    function automatic logic is_page_code(input logic [2:0] code);
        return code == LEN_CODE_PAGE;
    endfunction

endpackage

// File: rtl/dqbt_seq.sv
module dqbt_seq
    import dqbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_rd,
    input  logic        cmd_wr,
    input  logic        cmd_stop,
    input  logic [2:0]  blen,
    input  logic        single_wr,
    output beat_e       beat,
    output logic        wr_start
);

    burst_st_t st_q, st_d;
    logic      rd_start;
    logic      start;
    logic      one_shot;
    logic      new_page;
    logic [LEFT_W-1:0] new_last;

    always_comb begin
        rd_start = cmd_rd;
        wr_start = cmd_wr & ~cmd_rd;
        start    = rd_start | wr_start;
        one_shot = wr_start & single_wr;
        new_page = is_page_code(blen) & ~one_shot;
        new_last = one_shot ? '0 : last_beat_idx(blen);
    end

    // Beat issued in this cycle
    always_comb begin
        if (rd_start)
            beat = BEAT_RD;
        else if (wr_start)
            beat = BEAT_WR;
        else if (cmd_stop)
            beat = BEAT_NONE;
        else if (st_q.act)
            beat = st_q.wr ? BEAT_WR : BEAT_RD;
        else
            beat = BEAT_NONE;
    end

    // Burst state for the following cycles
    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.wr   = wr_start;
            st_d.page = new_page;
            st_d.left = new_page ? '0 : new_last;
            st_d.act  = new_page | (new_last != '0);
        end else if (cmd_stop) begin
            st_d.act = 1'b0;
        end else if (st_q.act && !st_q.page) begin
            st_d.left = st_q.left - LEFT_W'(1);
            st_d.act  = (st_q.left != LEFT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/dqbt_rdpipe.sv
module dqbt_rdpipe
    import dqbt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SHORT_LAT = 2,
    parameter int LONG_LAT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              flush,
    input  logic              lat_sel,
    input  logic              dqm,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic [LONG_LAT:1]   vld_q;
    logic [DATA_W-1:0]   dat_q [LONG_LAT:1];
    logic [MASK_LAG:1]   msk_q;
    logic                tap_vld;
    logic [DATA_W-1:0]   tap_dat;

    // Valid flags: a write start clears every pending read word
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else begin
            vld_q[1] <= issue;
            for (int i = 2; i <= LONG_LAT; i++)
                vld_q[i] <= vld_q[i-1];
        end
    end

    // Data words travel alongside their flags
    always_ff @(posedge clk) begin
        dat_q[1] <= rdata;
        for (int i = 2; i <= LONG_LAT; i++)
            dat_q[i] <= dat_q[i-1];
    end

    // Mask history, fixed lag independent of the column latency
    always_ff @(posedge clk) begin
        if (rst) begin
            msk_q <= '0;
        end else begin
            msk_q[1] <= dqm;
            for (int i = 2; i <= MASK_LAG; i++)
                msk_q[i] <= msk_q[i-1];
        end
    end

    always_comb begin
        tap_vld = lat_sel ? vld_q[LONG_LAT] : vld_q[SHORT_LAT];
        tap_dat = lat_sel ? dat_q[LONG_LAT] : dat_q[SHORT_LAT];
        dq_oe   = tap_vld & ~msk_q[MASK_LAG];
        dq_out  = dq_oe ? tap_dat : '0;
    end

endmodule

// File: rtl/dqbt_wrpath.sv
module dqbt_wrpath
    import dqbt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  beat_e             beat,
    input  logic              dqm,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wbeat,
    output logic              we,
    output logic [DATA_W-1:0] wdata
);

    always_comb begin
        wbeat = (beat == BEAT_WR);
        we    = wbeat & ~dqm;
        wdata = wbeat ? dq_in : '0;
    end

endmodule

// File: rtl/dq_burst_timer.sv
module dq_burst_timer
    import dqbt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SHORT_LAT = 2,
    parameter int LONG_LAT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              cmd_stop,
    input  logic              lat_sel,
    input  logic [2:0]        blen,
    input  logic              single_wr,
    input  logic              dqm,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              arr_re,
    output logic              arr_wbeat,
    output logic              arr_we,
    output logic [DATA_W-1:0] arr_wdata
);

    beat_e beat;
    logic  wr_start;

    dqbt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .cmd_stop  (cmd_stop),
        .blen      (blen),
        .single_wr (single_wr),
        .beat      (beat),
        .wr_start  (wr_start)
    );

    assign arr_re = (beat == BEAT_RD);

    dqbt_rdpipe #(
        .DATA_W    (DATA_W),
        .SHORT_LAT (SHORT_LAT),
        .LONG_LAT  (LONG_LAT)
    ) u_rdpipe (
        .clk     (clk),
        .rst     (rst),
        .issue   (arr_re),
        .flush   (wr_start),
        .lat_sel (lat_sel),
        .dqm     (dqm),
        .rdata   (arr_rdata),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    dqbt_wrpath #(
        .DATA_W (DATA_W)
    ) u_wrpath (
        .beat  (beat),
        .dqm   (dqm),
        .dq_in (dq_in),
        .wbeat (arr_wbeat),
        .we    (arr_we),
        .wdata (arr_wdata)
    );

endmodule

// File: rtl/dq_burst_timer_chk.sv
module dq_burst_timer_chk (
    input logic clk,
    input logic rst,
    input logic cmd_rd,
    input logic cmd_wr,
    input logic cmd_stop,
    input logic lat_sel,
    input logic single_wr,
    input logic dqm,
    input logic dq_oe,
    input logic arr_re,
    input logic arr_wbeat
);

    AST_OUT_AFTER_LAT2: assert property (@(posedge clk) disable iff (rst)
        (!lat_sel && dq_oe) |-> $past(arr_re, 2)); // R1

    AST_OUT_AFTER_LAT3: assert property (@(posedge clk) disable iff (rst)
        (lat_sel && dq_oe) |-> $past(arr_re, 3)); // R1

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(arr_re && arr_wbeat)); // R2

    AST_READ_MASK_LAG: assert property (@(posedge clk) disable iff (rst)
        $past(dqm, 2) |-> !dq_oe); // R5

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_stop && !cmd_rd && !cmd_wr) |-> (!arr_re && !arr_wbeat)); // R6

    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (rst)
        (single_wr && $past(single_wr) && $past(cmd_wr && !cmd_rd))
            |-> (!arr_wbeat || cmd_wr)); // R7

    AST_WRITE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_wr && !cmd_rd) |-> !dq_oe); // R10

endmodule

bind dq_burst_timer dq_burst_timer_chk u_chk (.*);

// File: tb/dq_burst_timer_test.sv
module dq_burst_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int SL = 2;
    localparam int LL = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_rd, cmd_wr, cmd_stop, lat_sel, single_wr, dqm;
    logic [2:0]    blen;
    logic [DW-1:0] arr_rdata, dq_in;
    logic [DW-1:0] dq_out, arr_wdata;
    logic          dq_oe, arr_re, arr_wbeat, arr_we;

    dq_burst_timer #(.DATA_W(DW), .SHORT_LAT(SL), .LONG_LAT(LL)) uut (
        .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop),
        .lat_sel(lat_sel), .blen(blen), .single_wr(single_wr), .dqm(dqm),
        .arr_rdata(arr_rdata), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .arr_re(arr_re), .arr_wbeat(arr_wbeat), .arr_we(arr_we), .arr_wdata(arr_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string tag = "R11";

    // Reference state built from the requirements
    bit            m_act, m_wr, m_page;
    int            m_left;
    bit            due_v [8];
    logic [DW-1:0] due_d [8];
    bit            off_at [8];
    int            cyc;
    int            seen_re, seen_wb, seen_we;

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    function automatic int fixed_len(input logic [2:0] c);
        case (c)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int lat_cycles(input logic s);
        return s ? LL : SL;
    endfunction

    task automatic model_clear();
        m_act = 0; m_wr = 0; m_page = 0; m_left = 0; cyc = 0;
        for (int i = 0; i < 8; i++) begin
            due_v[i] = 0; due_d[i] = '0; off_at[i] = 0;
        end
    endtask

    // One bus cycle: drive, check at mid-cycle, advance the reference
    task automatic step(input bit rd, input bit wr, input bit stp, input bit msk);
        int            kind;
        int            slot;
        bit            exp_oe;
        logic [DW-1:0] rdat, din;
        rdat = DW'($urandom);
        din  = DW'($urandom);
        cmd_rd = rd; cmd_wr = wr; cmd_stop = stp; dqm = msk;
        arr_rdata = rdat; dq_in = din;

        if (rd)       kind = 1;
        else if (wr)  kind = 2;
        else if (stp) kind = 0;
        else if (m_act) kind = m_wr ? 2 : 1;
        else          kind = 0;

        slot   = cyc % 8;
        exp_oe = due_v[slot] && !off_at[slot];

        #(CLK_PERIOD/2 - 1);
        check("dq_oe", 32'(dq_oe), 32'(exp_oe));
        check("dq_out", 32'(dq_out), exp_oe ? 32'(due_d[slot]) : 32'd0);
        check("arr_re", 32'(arr_re), 32'(kind == 1));
        check("arr_wbeat", 32'(arr_wbeat), 32'(kind == 2));
        check("arr_we", 32'(arr_we), 32'(kind == 2 && !msk));
        check("arr_wdata", 32'(arr_wdata), (kind == 2) ? 32'(din) : 32'd0);
        if (arr_re)    seen_re++;
        if (arr_wbeat) seen_wb++;
        if (arr_we)    seen_we++;

        due_v[slot] = 0; off_at[slot] = 0;
        if (msk) off_at[(cyc + 2) % 8] = 1;
        if (wr && !rd)
            for (int i = 0; i < 8; i++) due_v[i] = 0;
        if (kind == 1) begin
            due_v[(cyc + lat_cycles(lat_sel)) % 8] = 1;
            due_d[(cyc + lat_cycles(lat_sel)) % 8] = rdat;
        end

        if (rd || wr) begin
            int len;
            m_wr   = !rd;
            len    = (m_wr && single_wr) ? 1 : fixed_len(blen);
            m_page = (blen == 3'b111) && !(m_wr && single_wr);
            m_left = len - 1;
            m_act  = m_page || len > 1;
        end else if (stp) begin
            m_act = 0;
        end else if (m_act && !m_page) begin
            m_left--;
            m_act = m_left > 0;
        end
        cyc++;

        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic zero_counts();
        seen_re = 0; seen_wb = 0; seen_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        rst = 1; cmd_rd = 0; cmd_wr = 0; cmd_stop = 0; lat_sel = 0;
        blen = 3'b010; single_wr = 0; dqm = 1; arr_rdata = '0; dq_in = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        model_clear();

        // R11: nothing runs after reset even though the mask was high during it
        tag = "R11 reset state";
        idle(3);

        // R1 R2: each fixed length at latency 2
        foreach (blen_list[i]) begin
            tag = "R1 R2 fixed length lat2";
            blen = blen_list[i];
            zero_counts();
            step(1, 0, 0, 0);
            idle(10);
            check("R2 read beat count", 32'(seen_re), 32'(fixed_len(blen)));
        end

        // R2: reserved code gives one beat
        tag = "R2 reserved code";
        blen = 3'b101; zero_counts();
        step(1, 0, 0, 0); idle(5);
        check("R2 reserved beats", 32'(seen_re), 32'd1);

        // R3: open page burst keeps running until the stop
        tag = "R3 open page";
        blen = 3'b111; zero_counts();
        step(1, 0, 0, 0); idle(20);
        check("R3 page beats before stop", 32'(seen_re), 32'd21);
        step(0, 0, 1, 0); idle(6);
        check("R3 page beats after stop", 32'(seen_re), 32'd21);

        // R5: read mask disables output two cycles later
        tag = "R5 read mask lat2";
        blen = 3'b011;
        step(1, 0, 0, 0); idle(1); step(0, 0, 0, 1); idle(2); step(0, 0, 0, 1); idle(6);

        // R4: write mask acts in the same cycle
        tag = "R4 write mask";
        blen = 3'b010; zero_counts();
        step(0, 1, 0, 0); step(0, 0, 0, 1); idle(4);
        check("R4 write beats", 32'(seen_wb), 32'd4);
        check("R4 enabled writes", 32'(seen_we), 32'd3);

        // R7: single write one beat, reads keep the burst length
        tag = "R7 single write";
        single_wr = 1; blen = 3'b011; zero_counts();
        step(0, 1, 0, 0); idle(4);
        check("R7 write beats", 32'(seen_wb), 32'd1);
        step(1, 0, 0, 0); idle(10);
        check("R7 read beats", 32'(seen_re), 32'd8);
        single_wr = 0;

        // R6: stop ends read and write bursts
        tag = "R6 stop";
        zero_counts();
        step(1, 0, 0, 0); idle(2); step(0, 0, 1, 0); idle(6);
        check("R6 read beats", 32'(seen_re), 32'd3);
        step(0, 1, 0, 0); idle(1); step(0, 0, 1, 0); idle(3);
        check("R6 write beats", 32'(seen_wb), 32'd2);

        // R8: restart mid-burst and priority in one cycle
        tag = "R8 truncate";
        zero_counts();
        step(1, 0, 0, 0); idle(1); step(1, 0, 0, 0); idle(10);
        check("R8 read beats", 32'(seen_re), 32'd10);
        tag = "R8 priority";
        zero_counts();
        step(1, 1, 1, 0); idle(10);
        check("R8 read wins", 32'(seen_re), 32'd8);
        check("R8 no write", 32'(seen_wb), 32'd0);
        step(0, 1, 1, 0); idle(10);
        check("R8 write wins", 32'(seen_wb), 32'd8);

        // R10 R5 R1: flush and mask at latency 3
        lat_sel = 1;
        tag = "R10 write flush lat3";
        step(1, 0, 0, 0); idle(1); step(0, 1, 0, 0); idle(9);
        tag = "R5 R1 read mask lat3";
        step(1, 0, 0, 0); step(0, 0, 0, 1); idle(10);

        // Random mix at each latency
        for (int ph = 0; ph < 2; ph++) begin
            lat_sel = ph[0];
            tag = ph == 0 ? "R1 R4 R5 R8 R9 random lat2" : "R1 R4 R5 R8 R9 R10 random lat3";
            for (int n = 0; n < 1500; n++) begin
                int pick;
                pick = int'($urandom % 6);
                blen = (pick == 5) ? 3'b111 : (pick == 4 ? 3'b100 : 3'(pick));
                single_wr = ($urandom % 4) == 0;
                step(($urandom % 8) == 0, ($urandom % 10) == 0,
                     ($urandom % 12) == 0, ($urandom % 5) == 0);
            end
            step(0, 0, 1, 0);
            idle(6);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    logic [2:0] blen_list [4] = '{3'b000, 3'b001, 3'b010, 3'b011};

endmodule